// File: doc/BRIEF.md
# Read Prefetch Subrequest Generator

This block sits between an upstream read port and a downstream read channel. It accepts one upstream read at a time and turns it into an ordered run of downstream subrequests. Each subrequest carries a dword-aligned address, a dword count and byte enables for its first and last dword. How much data is asked for depends on the command type and on a small set of prefetch settings that are sampled when the read is accepted. A plain read asks only for its first data beat. A prefetched read runs to the end of its 64-byte block and then on through zero to seven further whole blocks. A split-transaction block read asks for exactly its byte count and is cut at every 64-byte boundary.

Every subrequest draws one credit from a pool that stands for the entries of the return data buffer. A pulse on the completion input gives one credit back. When the pool is empty, no subrequest is offered. A one-cycle done pulse marks the end of each upstream read. The block takes a new read only while it is idle.

Top module: `rd_subreq_gen`

## Requirements
- R1: `req_ready` is high exactly when no read is in progress, and a read is accepted on a clock edge where `req_valid` and `req_ready` are both high. `done` is high for one cycle, in the cycle after the handshake of the last subrequest, and `req_ready` is high again in that same cycle.
- R2: Command codes are 0 I/O read, 1 memory read, 2 memory read line, 3 memory read multiple, 4 block read. An I/O read is never prefetched. Code 2 is prefetched when `cfg_pref_en` and `cfg_line_pf` are both set, and then uses `cfg_line_depth`. Code 3 is prefetched when `cfg_pref_en` and `cfg_mult_pf` are both set, and then uses `cfg_mult_depth`. Code 1 is prefetched only when `cfg_pref_en`, `cfg_memrd_pf` and `cfg_line_pf` are all set, and then uses `cfg_line_depth`. When `cfg_pref_en` is clear, none of codes 0 to 3 is prefetched.
- R3: A prefetched read emits first the dwords from its dword-aligned start up to the end of the 64-byte block that holds it, and then depth (0 to 7) subrequests of 16 dwords at the following block addresses, in ascending order. All of these carry byte enables 4'b1111.
- R4: A read of codes 0 to 3 that is not prefetched, on a 32-bit bus (`req_bus64`=0), emits one subrequest of 1 dword at the dword-aligned start address, with both byte-enable fields equal to `req_be[3:0]`.
- R5: The same kind of read on a 64-bit bus uses the qword-aligned address A, with lo=`req_be[3:0]` and hi=`req_be[7:4]`. If hi=0, it emits 1 dword at A with enables lo (this includes all enables clear). If lo=0 and hi is non-zero, it emits 1 dword at A+4 with enables hi. If both halves are non-zero and the enabled bytes form one unbroken run, it emits 2 dwords at A with first enables lo and last enables hi. Otherwise it emits two single-dword subrequests, A with lo and then A+4 with hi.
- R6: A block read (code 4) ignores every prefetch setting and the byte enables. It covers exactly `req_bcnt` bytes from `req_addr` (a count of 0 means 4096). The range is cut so that no subrequest crosses a 64-byte boundary. The first-dword enables have a bit set for each covered byte of that dword (bit i for byte address offset i), and the last-dword enables likewise.
- R7: A subrequest is offered only while the credit pool is non-zero. The pool starts at `NUM_CREDITS` (default 8) and never holds more. Each handshake takes one credit and each `cpl_ret` pulse returns one, so no more than `NUM_CREDITS` subrequests are ever outstanding.
- R8: While `sub_valid` is high and `sub_ready` is low, the subrequest stays offered with address, count and enables unchanged.
- R9: A subrequest of one dword carries the same value on `sub_first_be` and `sub_last_be`. For a partial single dword, that value is the intersection of the start and end masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream read presented |
| req_ready | output | 1 | Block idle, read will be taken |
| req_cmd | input | 3 | Command code (R2) |
| req_addr | input | ADDR_W | Start byte address |
| req_be | input | 8 | Byte enables of the first data beat |
| req_bus64 | input | 1 | Upstream bus is 64 bits wide |
| req_bcnt | input | BCNT_W | Byte count for block reads, 0 = 4096 |
| cfg_pref_en | input | 1 | Global prefetch enable |
| cfg_memrd_pf | input | 1 | Let plain memory reads follow the line setting |
| cfg_line_pf | input | 1 | Prefetch enable for read line |
| cfg_line_depth | input | 3 | Extra whole blocks for read line |
| cfg_mult_pf | input | 1 | Prefetch enable for read multiple |
| cfg_mult_depth | input | 3 | Extra whole blocks for read multiple |
| sub_valid | output | 1 | Subrequest offered |
| sub_ready | input | 1 | Downstream takes subrequest |
| sub_addr | output | ADDR_W | Dword-aligned subrequest address |
| sub_dwords | output | 5 | Dword count, 1 to 16 |
| sub_first_be | output | 4 | Enables of the first dword |
| sub_last_be | output | 4 | Enables of the last dword |
| cpl_ret | input | 1 | One return buffer entry freed |
| done | output | 1 | Last subrequest of the read issued |

## Verification
The hardest state to reach from the ports is a read stalled halfway because the credit pool is empty. Completions must stop exactly while a long read is issuing, and no earlier traffic may still hold credits. The bench first waits until every earlier subrequest has been returned. It then gates off the completion pulses and starts a 4096-byte block read. It checks that exactly eight subrequests leave, that `sub_valid` then stays low with the read still busy, and that the full sequence finishes in order once completions resume. Elsewhere, a pseudo-random `sub_ready` and delayed completions keep the stall paths busy throughout the sweeps over byte enables, offsets, depths and byte counts.

// File: rtl/rd_subreq_pkg.sv
package rd_subreq_pkg;

  typedef enum logic [2:0] {
    CMD_IO   = 3'd0,
    CMD_MEM  = 3'd1,
    CMD_LINE = 3'd2,
    CMD_MULT = 3'd3,
    CMD_BLK  = 3'd4
  } rd_cmd_e;

  localparam int REM_W = 16;

  typedef struct packed {
    logic [6:0] take;    // bytes consumed from the range
    logic [4:0] dwords;
    logic [3:0] fbe;
    logic [3:0] lbe;
  } sub_shape_t;

  // Shape of the next piece of a byte range: stops at the 64-byte boundary.
  function automatic sub_shape_t range_shape(input logic [5:0] off,
                                             input logic [REM_W-1:0] rem);
    sub_shape_t s;
    logic [6:0] room;
    logic [6:0] take;
    logic [7:0] span;
    logic [1:0] lastb;
    room  = 7'd64 - {1'b0, off};
    take  = (rem < {{(REM_W-7){1'b0}}, room}) ? rem[6:0] : room;
    span  = {6'd0, off[1:0]} + {1'b0, take} + 8'd3;
    lastb = off[1:0] + take[1:0] - 2'd1;
    s.take   = take;
    s.dwords = span[6:2];
    s.fbe    = 4'hF << off[1:0];
    s.lbe    = 4'hF >> (2'd3 - lastb);
    if (s.dwords == 5'd1) begin
      s.fbe = s.fbe & s.lbe;
      s.lbe = s.fbe;
    end
    return s;
  endfunction

  // True when the set enables form a single unbroken run.
  function automatic logic be_one_run(input logic [7:0] be);
    logic [3:0] runs;
    runs = {3'd0, be[0]};
    for (int i = 1; i < 8; i++) runs = runs + {3'd0, be[i] & ~be[i-1]};
    return runs == 4'd1;
  endfunction

endpackage

// File: rtl/rd_subreq_policy.sv
module rd_subreq_policy
  import rd_subreq_pkg::*;
(
  input  logic [2:0] cmd,
  input  logic       pref_en,
  input  logic       memrd_pf,
  input  logic       line_pf,
  input  logic [2:0] line_depth,
  input  logic       mult_pf,
  input  logic [2:0] mult_depth,
  output logic       pf_en,
  output logic [2:0] pf_depth
);

  always_comb begin
    pf_en    = 1'b0;
    pf_depth = 3'd0;
    case (rd_cmd_e'(cmd))
      CMD_MEM: begin
        pf_en    = pref_en & memrd_pf & line_pf;
        pf_depth = line_depth;
      end
      CMD_LINE: begin
        pf_en    = pref_en & line_pf;
        pf_depth = line_depth;
      end
      CMD_MULT: begin
        pf_en    = pref_en & mult_pf;
        pf_depth = mult_depth;
      end
      default: begin
        pf_en    = 1'b0;
        pf_depth = 3'd0;
      end
    endcase
  end

endmodule

// File: rtl/rd_subreq_credit.sv
module rd_subreq_credit #(
  parameter int NUM_CREDITS = 8,
  parameter int CW          = $clog2(NUM_CREDITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count,
  output logic          avail
);

  localparam logic [CW-1:0] FULL = CW'(NUM_CREDITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= FULL;
    end else begin
      case ({take, give})
        2'b10:   count <= count - 1'b1;
        2'b01:   if (count != FULL) count <= count + 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign avail = (count != '0);

endmodule

// File: rtl/rd_subreq_seq.sv
module rd_subreq_seq
  import rd_subreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        be,
  input  logic              bus64,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic              pf_en,
  input  logic [2:0]        pf_depth,
  output logic              busy,
  output logic [ADDR_W-1:0] o_addr,
  output logic [4:0]        o_dwords,
  output logic [3:0]        o_fbe,
  output logic [3:0]        o_lbe,
  output logic              done
);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [4:0]        dwords;
    logic [3:0]        fbe;
    logic [3:0]        lbe;
  } desc_t;

  localparam logic [REM_W-1:0] BCNT_MAX = REM_W'(1 << BCNT_W);

  logic              range_q, two_q;
  logic [ADDR_W-1:0] cur_q;
  logic [REM_W-1:0]  rem_q;
  desc_t             fix0_q, fix1_q;

  desc_t             nf0, nf1;
  logic              ntwo;
  logic [REM_W-1:0]  start_rem;
  logic              is_blk;
  logic [ADDR_W-1:0] base4, base8;
  logic [3:0]        lo, hi;
  sub_shape_t        shp;
  logic              last;

  assign is_blk = (rd_cmd_e'(cmd) == CMD_BLK);
  assign base4  = {addr[ADDR_W-1:2], 2'b00};
  assign base8  = {addr[ADDR_W-1:3], 3'b000};
  assign lo     = be[3:0];
  assign hi     = be[7:4];

  // First-beat descriptors for reads that are not prefetched.
  always_comb begin
    nf0  = '{addr: base4, dwords: 5'd1, fbe: lo, lbe: lo};
    nf1  = '{addr: base8 + ADDR_W'(4), dwords: 5'd1, fbe: hi, lbe: hi};
    ntwo = 1'b0;
    if (bus64) begin
      if (hi == 4'd0) begin
        nf0 = '{addr: base8, dwords: 5'd1, fbe: lo, lbe: lo};
      end else if (lo == 4'd0) begin
        nf0 = '{addr: base8 + ADDR_W'(4), dwords: 5'd1, fbe: hi, lbe: hi};
      end else if (be_one_run(be)) begin
        nf0 = '{addr: base8, dwords: 5'd2, fbe: lo, lbe: hi};
      end else begin
        nf0  = '{addr: base8, dwords: 5'd1, fbe: lo, lbe: lo};
        ntwo = 1'b1;
      end
    end
  end

  always_comb begin
    if (is_blk)
      start_rem = (bcnt == '0) ? BCNT_MAX : REM_W'(bcnt);
    else
      start_rem = REM_W'(7'd64 - {1'b0, addr[5:2], 2'b00}) +
                  REM_W'({pf_depth, 6'd0});
  end

  assign shp  = range_shape(cur_q[5:0], rem_q);
  assign last = range_q ? (rem_q == REM_W'(shp.take)) : !two_q;

  always_comb begin
    if (range_q) begin
      o_addr   = {cur_q[ADDR_W-1:2], 2'b00};
      o_dwords = shp.dwords;
      o_fbe    = shp.fbe;
      o_lbe    = shp.lbe;
    end else begin
      o_addr   = fix0_q.addr;
      o_dwords = fix0_q.dwords;
      o_fbe    = fix0_q.fbe;
      o_lbe    = fix0_q.lbe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      range_q <= 1'b0;
      two_q   <= 1'b0;
      cur_q   <= '0;
      rem_q   <= '0;
      fix0_q  <= '0;
      fix1_q  <= '0;
    end else begin
      done <= adv & last;
      if (start) begin
        busy    <= 1'b1;
        range_q <= is_blk | pf_en;
        cur_q   <= is_blk ? addr : base4;
        rem_q   <= start_rem;
        fix0_q  <= nf0;
        fix1_q  <= nf1;
        two_q   <= ntwo & ~is_blk & ~pf_en;
      end else if (adv) begin
        if (last) busy <= 1'b0;
        if (range_q) begin
          cur_q <= cur_q + ADDR_W'(shp.take);
          rem_q <= rem_q - REM_W'(shp.take);
        end else if (two_q) begin
          fix0_q <= fix1_q;
          two_q  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rd_subreq_gen.sv
module rd_subreq_gen
  import rd_subreq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BCNT_W      = 12,
  parameter int NUM_CREDITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_be,
  input  logic              req_bus64,
  input  logic [BCNT_W-1:0] req_bcnt,
  input  logic              cfg_pref_en,
  input  logic              cfg_memrd_pf,
  input  logic              cfg_line_pf,
  input  logic [2:0]        cfg_line_depth,
  input  logic              cfg_mult_pf,
  input  logic [2:0]        cfg_mult_depth,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [4:0]        sub_dwords,
  output logic [3:0]        sub_first_be,
  output logic [3:0]        sub_last_be,
  input  logic              cpl_ret,
  output logic              done
);

  localparam int CW = $clog2(NUM_CREDITS + 1);

  logic          busy;
  logic          accept;
  logic          issue;
  logic          credit_ok;
  logic [CW-1:0] credit_cnt;
  logic          pf_en;
  logic [2:0]    pf_depth;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign sub_valid = busy & credit_ok;
  assign issue     = sub_valid & sub_ready;

  rd_subreq_policy u_policy (
    .cmd        (req_cmd),
    .pref_en    (cfg_pref_en),
    .memrd_pf   (cfg_memrd_pf),
    .line_pf    (cfg_line_pf),
    .line_depth (cfg_line_depth),
    .mult_pf    (cfg_mult_pf),
    .mult_depth (cfg_mult_depth),
    .pf_en      (pf_en),
    .pf_depth   (pf_depth)
  );

  rd_subreq_seq #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .adv      (issue),
    .cmd      (req_cmd),
    .addr     (req_addr),
    .be       (req_be),
    .bus64    (req_bus64),
    .bcnt     (req_bcnt),
    .pf_en    (pf_en),
    .pf_depth (pf_depth),
    .busy     (busy),
    .o_addr   (sub_addr),
    .o_dwords (sub_dwords),
    .o_fbe    (sub_first_be),
    .o_lbe    (sub_last_be),
    .done     (done)
  );

  rd_subreq_credit #(.NUM_CREDITS(NUM_CREDITS), .CW(CW)) u_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (issue),
    .give  (cpl_ret),
    .count (credit_cnt),
    .avail (credit_ok)
  );

endmodule

// File: rtl/rd_subreq_chk.sv
module rd_subreq_chk #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CREDITS = 8,
  parameter int CW          = $clog2(NUM_CREDITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic [ADDR_W-1:0] sub_addr,
  input logic [4:0]        sub_dwords,
  input logic [3:0]        sub_first_be,
  input logic [3:0]        sub_last_be,
  input logic              cpl_ret,
  input logic              done,
  input logic [CW-1:0]     credit_cnt
);

  p_done_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sub_valid && sub_ready));

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !sub_valid));

  p_no_block_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ((6'(sub_addr[5:2]) + 6'(sub_dwords)) <= 6'd16 && sub_dwords != 5'd0));

  p_credit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    credit_cnt <= CW'(NUM_CREDITS));

  p_credit_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_ready && !cpl_ret) |=> credit_cnt == CW'($past(credit_cnt) - 1'b1));

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=>
      (sub_valid && $stable(sub_addr) && $stable(sub_dwords) &&
       $stable(sub_first_be) && $stable(sub_last_be)));

  p_single_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_dwords == 5'd1) |-> sub_first_be == sub_last_be);

endmodule

bind rd_subreq_gen rd_subreq_chk #(
  .ADDR_W      (ADDR_W),
  .NUM_CREDITS (NUM_CREDITS),
  .CW          (CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .sub_valid    (sub_valid),
  .sub_ready    (sub_ready),
  .sub_addr     (sub_addr),
  .sub_dwords   (sub_dwords),
  .sub_first_be (sub_first_be),
  .sub_last_be  (sub_last_be),
  .cpl_ret      (cpl_ret),
  .done         (done),
  .credit_cnt   (credit_cnt)
);

// File: tb/tb_rd_subreq_gen.sv
module tb_rd_subreq_gen;
  localparam int AW = 32;
  localparam int BW = 12;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [2:0]    req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_be = '0;
  logic          req_bus64 = 1'b0;
  logic [BW-1:0] req_bcnt = '0;
  logic          c_pe = 0, c_mre = 0, c_le = 0, c_me = 0;
  logic [2:0]    c_ld = 0, c_md = 0;
  logic          sub_valid, sub_ready = 1'b1;
  logic [AW-1:0] sub_addr;
  logic [4:0]    sub_dwords;
  logic [3:0]    sub_first_be, sub_last_be;
  logic          cpl_ret = 1'b0;
  logic          done;

  rd_subreq_gen #(.ADDR_W(AW), .BCNT_W(BW), .NUM_CREDITS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be), .req_bus64(req_bus64),
    .req_bcnt(req_bcnt), .cfg_pref_en(c_pe), .cfg_memrd_pf(c_mre), .cfg_line_pf(c_le),
    .cfg_line_depth(c_ld), .cfg_mult_pf(c_me), .cfg_mult_depth(c_md),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_dwords(sub_dwords), .sub_first_be(sub_first_be), .sub_last_be(sub_last_be),
    .cpl_ret(cpl_ret), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  logic [44:0] exp_d [0:127];
  logic [44:0] got_d [0:127];
  int e_n, g_n, n_done, outst;
  bit cpl_en = 1;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Ready and completion drivers, just after each rising edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sub_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[2] | lfsr[5]);
    cpl_ret   = cpl_en && (outst > 0) && (lfsr[1:0] != 2'b00);
  end

  // Monitor, on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sub_valid && sub_ready) begin
        if (g_n < 128) got_d[g_n] = {sub_addr, sub_dwords, sub_first_be, sub_last_be};
        g_n++;
        outst++;
      end
      if (cpl_ret) outst--;
      if (outst > NC) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 outstanding actual=%0d expected<=%0d", outst, NC);
      end
      if (done) n_done++;
    end
  end

  // Byte walk of a range: one entry per 64-byte block touched.
  task automatic exp_range(input logic [31:0] start, input int nbytes);
    logic [31:0] a;
    logic [25:0] blk;
    logic [29:0] fdw, ldw;
    logic [3:0] fm, lm;
    e_n = 0;
    blk = '0; fdw = '0; ldw = '0; fm = '0; lm = '0;
    for (int b = 0; b < nbytes; b++) begin
      a = start + b;
      if (b == 0 || a[31:6] != blk) begin
        blk = a[31:6];
        fdw = a[31:2]; ldw = a[31:2];
        fm = 4'b0001 << a[1:0]; lm = fm;
        e_n++;
      end else if (a[31:2] == ldw) begin
        lm = lm | (4'b0001 << a[1:0]);
        if (ldw == fdw) fm = lm;
      end else begin
        ldw = a[31:2];
        lm = 4'b0001 << a[1:0];
      end
      if (e_n <= 128)
        exp_d[e_n-1] = {fdw, 2'b00, 5'(ldw - fdw + 1), fm, lm};
    end
  endtask

  task automatic build_exp(input logic [2:0] cmd, input logic [31:0] addr,
                           input logic [7:0] be, input logic b64, input int bcnt);
    bit pf; int d; int lo_i, hi_i, pc;
    logic [31:0] s, q;
    pf = 0; d = 0;
    case (cmd)
      3'd1: begin pf = c_pe && c_mre && c_le; d = c_ld; end
      3'd2: begin pf = c_pe && c_le; d = c_ld; end
      3'd3: begin pf = c_pe && c_me; d = c_md; end
      default: pf = 0;
    endcase
    if (cmd == 3'd4) begin
      exp_range(addr, (bcnt == 0) ? 4096 : bcnt);
    end else if (pf) begin
      s = addr & ~32'd3;
      exp_range(s, 64 - (s % 64) + 64 * d);
    end else if (!b64) begin
      e_n = 1;
      exp_d[0] = {addr & ~32'd3, 5'd1, be[3:0], be[3:0]};
    end else begin
      q = addr & ~32'd7;
      lo_i = -1; hi_i = -1; pc = 0;
      for (int i = 0; i < 8; i++) if (be[i]) begin
        if (lo_i < 0) lo_i = i;
        hi_i = i; pc++;
      end
      e_n = 1;
      if (be[7:4] == 0)      exp_d[0] = {q, 5'd1, be[3:0], be[3:0]};
      else if (be[3:0] == 0) exp_d[0] = {q + 32'd4, 5'd1, be[7:4], be[7:4]};
      else if (pc == hi_i - lo_i + 1) exp_d[0] = {q, 5'd2, be[3:0], be[7:4]};
      else begin
        e_n = 2;
        exp_d[0] = {q, 5'd1, be[3:0], be[3:0]};
        exp_d[1] = {q + 32'd4, 5'd1, be[7:4], be[7:4]};
      end
    end
  endtask

  task automatic start_req(input logic [2:0] cmd, input logic [31:0] addr,
                           input logic [7:0] be, input logic b64, input int bcnt);
    build_exp(cmd, addr, be, b64, bcnt);
    @(posedge clk); #2;
    g_n = 0; n_done = 0;
    req_cmd = cmd; req_addr = addr; req_be = be; req_bus64 = b64;
    req_bcnt = BW'(bcnt); req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic finish_req(input string tag);
    int t = 0;
    while (n_done == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(n_done == 1, "R1", {tag, " done pulses"}, 64'(n_done), 64'd1);
    chk(g_n == e_n, tag, "subrequest count", 64'(g_n), 64'(e_n));
    for (int k = 0; k < e_n && k < g_n && k < 128; k++)
      chk(got_d[k] == exp_d[k], tag, $sformatf("subrequest %0d", k),
          64'(got_d[k]), 64'(exp_d[k]));
  endtask

  task automatic run(input string tag, input logic [2:0] cmd, input logic [31:0] addr,
                     input logic [7:0] be, input logic b64, input int bcnt);
    start_req(cmd, addr, be, b64, bcnt);
    finish_req(tag);
  endtask

  initial begin
    g_n = 0; e_n = 0; n_done = 0; outst = 0;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    chk(sub_valid == 1'b0, "R7", "valid in reset", 64'(sub_valid), 64'd0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !sub_valid && !done, "R1", "idle after reset",
        64'({req_ready, sub_valid, done}), 64'b100);

    // R5: every byte-enable pattern on a 64-bit bus, plain reads.
    for (int b = 0; b < 256; b++) begin
      rdy_mode = b % 2;
      run("R5", 3'(b % 2), 32'h1000_0000 + 32'(b * 8) + 32'((b % 3) * 4), 8'(b), 1'b1, 0);
    end

    // R4: 32-bit bus, all lower-half patterns, upper half ignored.
    for (int b = 0; b < 16; b++) begin
      rdy_mode = 1;
      run("R4", 3'd2, 32'h2000_0003 + 32'(b * 4), {4'(15 - b), 4'(b)}, 1'b0, 0);
    end

    // R2/R3: policy matrix over commands, settings, depths and offsets.
    for (int c = 0; c < 16; c++) begin
      c_pe = c[0]; c_mre = c[1]; c_le = c[2]; c_me = c[3];
      for (int d = 0; d < 8; d++) begin
        c_ld = 3'(d); c_md = 3'(7 - d);
        for (int cmd = 0; cmd < 4; cmd++) begin
          for (int o = 0; o < 3; o++) begin
            rdy_mode = (c + d + o) % 2;
            run((cmd == 0) ? "R2 io" : "R2/R3", 3'(cmd),
                32'h3000_0000 + 32'(d * 4096) + ((o == 0) ? 32'd2 : (o == 1) ? 32'd28 : 32'd61),
                8'h3C, 1'(o), 0);
          end
        end
      end
    end

    // R6/R9: block reads over offsets and short to medium byte counts.
    c_pe = 1; c_mre = 1; c_le = 1; c_me = 1; c_ld = 3'd7; c_md = 3'd7;
    for (int o = 0; o < 7; o++) begin
      for (int n = 1; n <= 130; n++) begin
        rdy_mode = n % 2;
        run("R6/R9", 3'd4,
            32'h4000_0000 + 32'(n * 256) + ((o < 5) ? 32'(o) : 32'(57 + o)),
            8'h00, 1'(n % 2), n);
      end
    end
    rdy_mode = 1;
    run("R6/R8", 3'd4, 32'h5000_0021, 8'hFF, 1'b1, 4095);
    run("R6/R8", 3'd4, 32'h5000_1003, 8'hFF, 1'b0, 0);

    // R7: starve credits during a 4096-byte block read.
    rdy_mode = 0;
    while (outst != 0) @(negedge clk);
    cpl_en = 0;
    start_req(3'd4, 32'h6000_0000, 8'h00, 1'b1, 0);
    repeat (30) @(negedge clk);
    chk(g_n == NC, "R7", "issued with no returns", 64'(g_n), 64'(NC));
    chk(sub_valid == 1'b0, "R7", "valid with empty pool", 64'(sub_valid), 64'd0);
    chk(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
    cpl_en = 1;
    finish_req("R7");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule